// File: doc/BRIEF.md
# SPI DAC Command Register Interface

This block is the device-side SPI target of a multi-channel DAC (16 channels of 16 bits by default). The host sends 24-bit frames, most-significant bit first. Each frame holds an 8-bit command followed by a 16-bit data word, high byte first. The block decodes per-channel and global commands and holds all the register state the analog side needs. That state is presented as parallel outputs, together with a one-cycle update strobe for each channel.

Each channel has two input code registers, A and B, plus an active DAC register and settings, offset and gain words. A select bitmap decides which input register a code command reaches. One command writes only the input register. A second command also moves the written value into the active register. A third command transfers every channel's selected input register at once. Reads take two frames: a read is requested in one frame, and the value is returned on MISO during the data bytes of the next frame, which is normally a no-op.

The SPI pins are sampled in the system clock domain through synchronisers, so SCLK must run well below the system clock. Mode 0 is used: MOSI is sampled on the rising SCLK edge and MISO advances on the falling edge.

Top module: `spi_dac_regs`

## Requirements
- R1: A frame counts only if exactly 24 SCLK rising edges occur while chip select is low. Bits arrive MSB first: command in bits 23..16, data in 15..0. Its effect appears only after chip select rises. Outputs stay unchanged while chip select remains high.
- R2: A frame that ends with fewer or more than 24 bits is discarded. It changes no register and does not alter the pending read reply.
- R3: A write to address 0x00+n (n below the channel count) loads input B of channel n if bit n of the select bitmap is 1, and input A if that bit is 0. The active register and the update strobes are unchanged.
- R4: A write to 0x40+n loads the selected input register of channel n and also the active register of channel n. It raises the update strobe of channel n alone for one cycle.
- R5: A write to 0x7C loads every channel's active register from its selected input register (B when its select bit is 1). It raises all update strobes in the same single cycle.
- R6: Writes to 0x10+n, 0x20+n and 0x30+n store the full 16-bit word as channel n's settings, offset and gain.
- R7: Writes to 0x70 store the config word. Writes to 0x71, 0x72, 0x73 and 0x74 store the low channel-count bits of the data as the power-down, A/B select, software-toggle and toggle/dither-enable bitmaps.
- R8: A config write with bit 15 set makes cfg_o show the written word for exactly one cycle. In the next cycle every register (inputs, active, settings, offset, gain, config and all bitmaps) becomes zero.
- R9: Setting bit 7 of the command requests a read of address bits 6..0. The next frame shifts out eight zero bits during its command byte, then the 16-bit value MSB first.
- R10: A read of 0x00+n returns input B of channel n when its select bit is 1, and input A when it is 0. Reads of 0x10+n, 0x20+n and 0x30+n return settings, offset and gain. Reads of 0x70 to 0x74 return config and the bitmaps.
- R11: Reads of 0x77 return thermal_i as it was when the read frame ended. Reads of 0x75, 0x76 and of any address outside 0x00-0x3F and 0x70-0x77 return zero, and so does the frame after any write frame.
- R12: Writes to 0x77 or above 0x7C, and to writable addresses with no storage behind them (0x50-0x6F, 0x75, 0x76, 0x78-0x7B), change nothing.
- R13: MISO is low whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | SPI serial clock |
| csn_i | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | SPI data from host |
| miso_o | output | 1 | SPI data to host |
| thermal_i | input | 16 | Thermal status word returned by reads of 0x77 |
| code_a_o | output | NCH*DW | Input A registers, channel n at bits n*DW +: DW |
| code_b_o | output | NCH*DW | Input B registers |
| dac_o | output | NCH*DW | Active DAC registers |
| setting_o | output | NCH*DW | Per-channel settings words |
| offset_o | output | NCH*DW | Per-channel offset words |
| gain_o | output | NCH*DW | Per-channel gain words |
| cfg_o | output | DW | Config register |
| pwrdn_o | output | NCH | Power-down bitmap |
| absel_o | output | NCH | A/B select bitmap, 1 selects B |
| swtog_o | output | NCH | Software toggle bitmap |
| tden_o | output | NCH | Toggle/dither enable bitmap |
| upd_o | output | NCH | One-cycle update strobes |

## Verification
State is visible on parallel ports as soon as a frame commits, so a wrong decode or a wrong A/B steering shows up within a few clocks of chip select rising. A comparison on every clock against the bench model catches it there. A corrupted read path stays hidden until the following frame, when the reply bits on MISO differ. A broken soft reset shows as config bit 15 staying high for more or fewer than one cycle, or as registers that survive it. Stray or missing update strobes show as per-channel strobe counts that disagree with the commands sent.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
  localparam int unsigned CMD_W  = 8;
  localparam int unsigned ADDR_W = 7;

  localparam logic [2:0] GRP_CODE = 3'd0;
  localparam logic [2:0] GRP_SET  = 3'd1;
  localparam logic [2:0] GRP_OFF  = 3'd2;
  localparam logic [2:0] GRP_GAIN = 3'd3;
  localparam logic [2:0] GRP_CUPD = 3'd4;
  localparam logic [2:0] GRP_GLOB = 3'd7;

  localparam logic [ADDR_W-1:0] A_CFG    = 7'h70;
  localparam logic [ADDR_W-1:0] A_PWRDN  = 7'h71;
  localparam logic [ADDR_W-1:0] A_ABSEL  = 7'h72;
  localparam logic [ADDR_W-1:0] A_SWTOG  = 7'h73;
  localparam logic [ADDR_W-1:0] A_TDEN   = 7'h74;
  localparam logic [ADDR_W-1:0] A_THERM  = 7'h77;
  localparam logic [ADDR_W-1:0] A_UPDALL = 7'h7C;

  typedef struct packed {
    logic code;
    logic cupd;
    logic set;
    logic off;
    logic gain;
  } chan_we_t;

  function automatic logic addr_readable(input logic [ADDR_W-1:0] a);
    return (a <= 7'h3F) || ((a >= A_CFG) && (a <= A_THERM));
  endfunction

  function automatic logic addr_writable(input logic [ADDR_W-1:0] a);
    return (a <= A_UPDALL) && (a != A_THERM);
  endfunction
endpackage

// File: rtl/sdr_spi_rx.sv
module sdr_spi_rx #(
  parameter int unsigned FW   = 24,
  parameter int unsigned SYNC = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sclk_i,
  input  logic          csn_i,
  input  logic          mosi_i,
  input  logic [FW-1:0] tx_data_i,
  output logic          frame_o,
  output logic [FW-1:0] frame_data_o,
  output logic          miso_o
);
  localparam int unsigned CNTW = $clog2(FW + 2);
  localparam logic [CNTW-1:0] FULL = CNTW'(FW);

  logic [SYNC:0]   sclk_s, csn_s;
  logic [SYNC-1:0] mosi_s;
  logic [CNTW-1:0] cnt_q;
  logic [FW-1:0]   rx_q, tx_q;
  logic sck_now, sck_old, cs_now, cs_old, mosi_now;
  logic sck_rise, sck_fall, cs_fall, cs_rise;

  assign sck_now  = sclk_s[SYNC-1];
  assign sck_old  = sclk_s[SYNC];
  assign cs_now   = csn_s[SYNC-1];
  assign cs_old   = csn_s[SYNC];
  assign mosi_now = mosi_s[SYNC-1];
  assign sck_rise = sck_now & ~sck_old;
  assign sck_fall = ~sck_now & sck_old;
  assign cs_fall  = cs_old & ~cs_now;
  assign cs_rise  = ~cs_old & cs_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_s <= '0;
      csn_s  <= '1;
      mosi_s <= '0;
    end else begin
      sclk_s <= {sclk_s[SYNC-1:0], sclk_i};
      csn_s  <= {csn_s[SYNC-1:0], csn_i};
      mosi_s <= {mosi_s[SYNC-2:0], mosi_i};
    end
  end

  // bit counter saturates so overlong frames never alias to a full one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rx_q  <= '0;
    end else if (cs_now) begin
      cnt_q <= '0;
    end else if (sck_rise) begin
      rx_q <= {rx_q[FW-2:0], mosi_now};
      if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 tx_q <= '0;
    else if (cs_fall)            tx_q <= tx_data_i;
    else if (!cs_now && sck_fall) tx_q <= {tx_q[FW-2:0], 1'b0};
  end

  assign frame_o      = cs_rise && (cnt_q == FULL);
  assign frame_data_o = rx_q;
  assign miso_o       = ~cs_now & tx_q[FW-1];
endmodule

// File: rtl/sdr_chan.sv
module sdr_chan
  import sdr_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  chan_we_t      we_i,
  input  logic          sel_b_i,
  input  logic          upd_all_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] code_a_o,
  output logic [DW-1:0] code_b_o,
  output logic [DW-1:0] dac_o,
  output logic [DW-1:0] set_o,
  output logic [DW-1:0] off_o,
  output logic [DW-1:0] gain_o,
  output logic          upd_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_a_o <= '0; code_b_o <= '0; dac_o <= '0;
      set_o <= '0; off_o <= '0; gain_o <= '0; upd_o <= 1'b0;
    end else if (clr_i) begin
      code_a_o <= '0; code_b_o <= '0; dac_o <= '0;
      set_o <= '0; off_o <= '0; gain_o <= '0; upd_o <= 1'b0;
    end else begin
      upd_o <= we_i.cupd | upd_all_i;
      if (we_i.code || we_i.cupd) begin
        if (sel_b_i) code_b_o <= wdata_i;
        else         code_a_o <= wdata_i;
      end
      if (we_i.cupd)     dac_o <= wdata_i;
      else if (upd_all_i) dac_o <= sel_b_i ? code_b_o : code_a_o;
      if (we_i.set)  set_o  <= wdata_i;
      if (we_i.off)  off_o  <= wdata_i;
      if (we_i.gain) gain_o <= wdata_i;
    end
  end
endmodule

// File: rtl/sdr_glob.sv
module sdr_glob
  import sdr_pkg::*;
#(
  parameter int unsigned NCH = 16,
  parameter int unsigned DW  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     cfg_o,
  output logic [NCH-1:0]    pwrdn_o,
  output logic [NCH-1:0]    absel_o,
  output logic [NCH-1:0]    swtog_o,
  output logic [NCH-1:0]    tden_o,
  output logic              clr_o
);
  // soft reset fires the cycle after the top config bit is seen
  assign clr_o = cfg_o[DW-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o <= '0; pwrdn_o <= '0; absel_o <= '0; swtog_o <= '0; tden_o <= '0;
    end else if (clr_o) begin
      cfg_o <= '0; pwrdn_o <= '0; absel_o <= '0; swtog_o <= '0; tden_o <= '0;
    end else if (wr_i) begin
      case (addr_i)
        A_CFG:   cfg_o   <= wdata_i;
        A_PWRDN: pwrdn_o <= wdata_i[NCH-1:0];
        A_ABSEL: absel_o <= wdata_i[NCH-1:0];
        A_SWTOG: swtog_o <= wdata_i[NCH-1:0];
        A_TDEN:  tden_o  <= wdata_i[NCH-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/spi_dac_regs.sv
module spi_dac_regs
  import sdr_pkg::*;
#(
  parameter int unsigned NCH  = 16,
  parameter int unsigned DW   = 16,
  parameter int unsigned SYNC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              csn_i,
  input  logic              mosi_i,
  output logic              miso_o,
  input  logic [DW-1:0]     thermal_i,
  output logic [NCH*DW-1:0] code_a_o,
  output logic [NCH*DW-1:0] code_b_o,
  output logic [NCH*DW-1:0] dac_o,
  output logic [NCH*DW-1:0] setting_o,
  output logic [NCH*DW-1:0] offset_o,
  output logic [NCH*DW-1:0] gain_o,
  output logic [DW-1:0]     cfg_o,
  output logic [NCH-1:0]    pwrdn_o,
  output logic [NCH-1:0]    absel_o,
  output logic [NCH-1:0]    swtog_o,
  output logic [NCH-1:0]    tden_o,
  output logic [NCH-1:0]    upd_o
);
  localparam int unsigned FW  = CMD_W + DW;
  localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [4:0]  NCH5 = 5'(NCH);

  logic              frm;
  logic [FW-1:0]     frm_data;
  logic [CMD_W-1:0]  cmd;
  logic [ADDR_W-1:0] addr;
  logic [DW-1:0]     wdata;
  logic [2:0]        grp;
  logic              is_rd, wr_ok, ch_ok, upd_all, clr;
  logic [DW-1:0]     rd_hold_q, rd_val;

  logic [DW-1:0] a_arr [NCH];
  logic [DW-1:0] b_arr [NCH];
  logic [DW-1:0] s_arr [NCH];
  logic [DW-1:0] o_arr [NCH];
  logic [DW-1:0] g_arr [NCH];

  sdr_spi_rx #(.FW(FW), .SYNC(SYNC)) u_rx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sclk_i       (sclk_i),
    .csn_i        (csn_i),
    .mosi_i       (mosi_i),
    .tx_data_i    ({{CMD_W{1'b0}}, rd_hold_q}),
    .frame_o      (frm),
    .frame_data_o (frm_data),
    .miso_o       (miso_o)
  );

  assign cmd     = frm_data[FW-1 -: CMD_W];
  assign wdata   = frm_data[DW-1:0];
  assign is_rd   = cmd[CMD_W-1];
  assign addr    = cmd[ADDR_W-1:0];
  assign grp     = addr[6:4];
  assign ch_ok   = ({1'b0, addr[3:0]} < NCH5);
  assign wr_ok   = frm && !is_rd && addr_writable(addr);
  assign upd_all = wr_ok && (addr == A_UPDALL);

  sdr_glob #(.NCH(NCH), .DW(DW)) u_glob (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_ok),
    .addr_i  (addr),
    .wdata_i (wdata),
    .cfg_o   (cfg_o),
    .pwrdn_o (pwrdn_o),
    .absel_o (absel_o),
    .swtog_o (swtog_o),
    .tden_o  (tden_o),
    .clr_o   (clr)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    chan_we_t we;
    logic     hit;
    assign hit     = wr_ok && (addr[3:0] == 4'(n));
    assign we.code = hit && (grp == GRP_CODE);
    assign we.cupd = hit && (grp == GRP_CUPD);
    assign we.set  = hit && (grp == GRP_SET);
    assign we.off  = hit && (grp == GRP_OFF);
    assign we.gain = hit && (grp == GRP_GAIN);

    sdr_chan #(.DW(DW)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (clr),
      .we_i      (we),
      .sel_b_i   (absel_o[n]),
      .upd_all_i (upd_all),
      .wdata_i   (wdata),
      .code_a_o  (a_arr[n]),
      .code_b_o  (b_arr[n]),
      .dac_o     (dac_o[n*DW +: DW]),
      .set_o     (s_arr[n]),
      .off_o     (o_arr[n]),
      .gain_o    (g_arr[n]),
      .upd_o     (upd_o[n])
    );

    assign code_a_o[n*DW +: DW]  = a_arr[n];
    assign code_b_o[n*DW +: DW]  = b_arr[n];
    assign setting_o[n*DW +: DW] = s_arr[n];
    assign offset_o[n*DW +: DW]  = o_arr[n];
    assign gain_o[n*DW +: DW]    = g_arr[n];
  end

  always_comb begin
    logic [CHW-1:0] ci;
    ci     = addr[CHW-1:0];
    rd_val = '0;
    if (addr_readable(addr)) begin
      case (grp)
        GRP_CODE: if (ch_ok) rd_val = absel_o[ci] ? b_arr[ci] : a_arr[ci];
        GRP_SET:  if (ch_ok) rd_val = s_arr[ci];
        GRP_OFF:  if (ch_ok) rd_val = o_arr[ci];
        GRP_GAIN: if (ch_ok) rd_val = g_arr[ci];
        GRP_GLOB: begin
          case (addr)
            A_CFG:   rd_val = cfg_o;
            A_PWRDN: rd_val[NCH-1:0] = pwrdn_o;
            A_ABSEL: rd_val[NCH-1:0] = absel_o;
            A_SWTOG: rd_val[NCH-1:0] = swtog_o;
            A_TDEN:  rd_val[NCH-1:0] = tden_o;
            A_THERM: rd_val = thermal_i;
            default: rd_val = '0;
          endcase
        end
        default: rd_val = '0;
      endcase
    end
  end

  // reply for the next frame; any full write frame clears it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rd_hold_q <= '0;
    else if (frm) rd_hold_q <= is_rd ? rd_val : '0;
  end
endmodule

// File: rtl/sdr_chk.sv
module sdr_chk #(
  parameter int unsigned NCH = 16,
  parameter int unsigned DW  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              csn_i,
  input logic              miso_o,
  input logic [NCH*DW-1:0] code_a_o,
  input logic [NCH*DW-1:0] code_b_o,
  input logic [NCH*DW-1:0] dac_o,
  input logic [NCH*DW-1:0] gain_o,
  input logic [DW-1:0]     cfg_o,
  input logic [NCH-1:0]    pwrdn_o,
  input logic [NCH-1:0]    absel_o,
  input logic [NCH-1:0]    upd_o
);
  AST_UPD_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(upd_o) || (&upd_o)); // R5

  AST_DAC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_o == '0 && !$past(cfg_o[DW-1])) |-> $stable(dac_o)); // R4

  AST_SOFT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_o[DW-1] |=> (cfg_o == '0 && pwrdn_o == '0 && absel_o == '0 &&
                     dac_o == '0 && code_a_o == '0 && code_b_o == '0)); // R8

  AST_MISO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csn_i && $past(csn_i) && $past(csn_i, 2) && $past(csn_i, 3)) |-> !miso_o); // R13

  AST_QUIET_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csn_i && $past(csn_i) && $past(csn_i, 2) && $past(csn_i, 3) &&
     $past(csn_i, 4) && $past(csn_i, 5) && $past(csn_i, 6))
    |-> ($stable(code_a_o) && $stable(code_b_o) && $stable(gain_o) &&
         $stable(cfg_o) && $stable(absel_o))); // R1
endmodule

bind spi_dac_regs sdr_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .csn_i    (csn_i),
  .miso_o   (miso_o),
  .code_a_o (code_a_o),
  .code_b_o (code_b_o),
  .dac_o    (dac_o),
  .gain_o   (gain_o),
  .cfg_o    (cfg_o),
  .pwrdn_o  (pwrdn_o),
  .absel_o  (absel_o),
  .upd_o    (upd_o)
);

// File: tb/tb_spi_dac_regs.sv
module tb_spi_dac_regs;
  localparam int NCH  = 16;
  localparam int DW   = 16;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic miso;
  logic [DW-1:0] therm = 16'h0000;
  logic [NCH*DW-1:0] code_a, code_b, dac, setting, offset, gain;
  logic [DW-1:0] cfg;
  logic [NCH-1:0] pwrdn, absel, swtog, tden, upd;

  always #2 clk = ~clk;

  spi_dac_regs dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .csn_i(csn), .mosi_i(mosi),
    .miso_o(miso), .thermal_i(therm), .code_a_o(code_a), .code_b_o(code_b),
    .dac_o(dac), .setting_o(setting), .offset_o(offset), .gain_o(gain),
    .cfg_o(cfg), .pwrdn_o(pwrdn), .absel_o(absel), .swtog_o(swtog),
    .tden_o(tden), .upd_o(upd)
  );

  // behavioural model
  logic [15:0] m_a[NCH], m_b[NCH], m_d[NCH], m_s[NCH], m_o[NCH], m_g[NCH];
  logic [15:0] m_cfg, m_pd, m_ab, m_sw, m_td, m_rd;
  int exp_upd[NCH], got_upd[NCH];
  int exp_all, got_all, exp_clr, got_clr;
  int tests = 0, fails = 0;
  bit chk_en = 0;
  string req = "R1";
  bit done = 0;

  task automatic check(input bit ok, input string r, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", r, what, act, exp);
    end
  endtask

  function automatic logic [255:0] mvec(input int k);
    logic [255:0] v = '0;
    for (int n = 0; n < NCH; n++) begin
      case (k)
        0: v[n*16 +: 16] = m_a[n];
        1: v[n*16 +: 16] = m_b[n];
        2: v[n*16 +: 16] = m_d[n];
        3: v[n*16 +: 16] = m_s[n];
        4: v[n*16 +: 16] = m_o[n];
        5: v[n*16 +: 16] = m_g[n];
        default: ;
      endcase
    end
    case (k)
      6:  v[15:0] = m_cfg;
      7:  v[15:0] = m_pd;
      8:  v[15:0] = m_ab;
      9:  v[15:0] = m_sw;
      10: v[15:0] = m_td;
      default: ;
    endcase
    return v;
  endfunction

  function automatic logic [255:0] dvec(input int k);
    case (k)
      0: return code_a;
      1: return code_b;
      2: return dac;
      3: return setting;
      4: return offset;
      5: return gain;
      6: return {240'd0, cfg};
      7: return {240'd0, pwrdn};
      8: return {240'd0, absel};
      9: return {240'd0, swtog};
      default: return {240'd0, tden};
    endcase
  endfunction

  // every-clock comparison and strobe monitors
  always @(negedge clk) begin
    if (rst_n) begin
      for (int n = 0; n < NCH; n++) if (upd[n]) got_upd[n]++;
      if (&upd) got_all++;
      if (cfg[15]) got_clr++;
    end
    if (rst_n && chk_en && !done) begin
      bit ok = 1;
      int bad = 0;
      for (int k = 0; k < 11; k++)
        if (ok && dvec(k) !== mvec(k)) begin ok = 0; bad = k; end
      check(ok, req, $sformatf("register group %0d", bad), dvec(bad), mvec(bad));
      if (csn) check(miso === 1'b0, "R13", "miso idle", {255'd0, miso}, 256'd0);
    end
  end

  function automatic logic [15:0] m_read(input logic [6:0] a);
    int c = a[3:0];
    if (a <= 7'h0F) return m_ab[c] ? m_b[c] : m_a[c];
    if (a <= 7'h1F) return m_s[c];
    if (a <= 7'h2F) return m_o[c];
    if (a <= 7'h3F) return m_g[c];
    case (a)
      7'h70: return m_cfg;
      7'h71: return m_pd;
      7'h72: return m_ab;
      7'h73: return m_sw;
      7'h74: return m_td;
      7'h77: return therm;
      default: return 16'h0;
    endcase
  endfunction

  task automatic m_apply(input logic [7:0] c, input logic [15:0] d);
    logic [6:0] a = c[6:0];
    int ch = a[3:0];
    if (c[7]) begin
      m_rd = ((a <= 7'h3F) || (a >= 7'h70 && a <= 7'h77)) ? m_read(a) : 16'h0;
      return;
    end
    m_rd = 16'h0;
    if (a > 7'h7C || a == 7'h77) return;
    if (a <= 7'h0F || (a >= 7'h40 && a <= 7'h4F)) begin
      if (m_ab[ch]) m_b[ch] = d; else m_a[ch] = d;
      if (a >= 7'h40) begin m_d[ch] = d; exp_upd[ch]++; end
    end else if (a <= 7'h1F) m_s[ch] = d;
    else if (a <= 7'h2F) m_o[ch] = d;
    else if (a <= 7'h3F) m_g[ch] = d;
    else case (a)
      7'h70: begin
        if (d[15]) begin
          exp_clr++;
          m_cfg = 0; m_pd = 0; m_ab = 0; m_sw = 0; m_td = 0;
          for (int n = 0; n < NCH; n++) begin
            m_a[n] = 0; m_b[n] = 0; m_d[n] = 0; m_s[n] = 0; m_o[n] = 0; m_g[n] = 0;
          end
        end else m_cfg = d;
      end
      7'h71: m_pd = d;
      7'h72: m_ab = d;
      7'h73: m_sw = d;
      7'h74: m_td = d;
      7'h7C: begin
        exp_all++;
        for (int n = 0; n < NCH; n++) begin
          m_d[n] = m_ab[n] ? m_b[n] : m_a[n];
          exp_upd[n]++;
        end
      end
      default: ;
    endcase
  endtask

  // one SPI frame, mode 0; nbits other than 24 gives a discarded frame
  task automatic xfer(input logic [7:0] c, input logic [15:0] d, input int nbits,
                      input string r);
    logic [31:0] w = {c, d, 8'h00};
    logic [23:0] got = '0;
    logic [15:0] exp_rd = m_rd;
    req = r;
    @(negedge clk) csn = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = w[31-i];
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
      if (i < 24) got[23-i] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    sclk = 1'b0;
    repeat (HALF) @(negedge clk);
    csn = 1'b1;
    chk_en = 0;
    repeat (12) @(negedge clk);
    if (nbits == 24) begin
      check(got === {8'h00, exp_rd}, (exp_rd != 0) ? "R9" : "R11", "read reply",
            {232'd0, got}, {240'd0, exp_rd});
      m_apply(c, d);
    end
    for (int n = 0; n < NCH; n++)
      check(got_upd[n] == exp_upd[n], (r == "R5") ? "R5" : "R4",
            $sformatf("strobe count ch%0d", n), got_upd[n], exp_upd[n]);
    check(got_all == exp_all, "R5", "all-channel strobe cycles", got_all, exp_all);
    check(got_clr == exp_clr, "R8", "config reset bit cycles", got_clr, exp_clr);
    chk_en = 1;
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    m_cfg = 0; m_pd = 0; m_ab = 0; m_sw = 0; m_td = 0; m_rd = 0;
    exp_all = 0; got_all = 0; exp_clr = 0; got_clr = 0;
    for (int n = 0; n < NCH; n++) begin
      m_a[n] = 0; m_b[n] = 0; m_d[n] = 0; m_s[n] = 0; m_o[n] = 0; m_g[n] = 0;
      exp_upd[n] = 0; got_upd[n] = 0;
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    req = "R1";
    chk_en = 1;
    repeat (4) @(negedge clk);

    // R3: code write to A, then to B after select bit set (R7)
    xfer(8'h03, 16'h1234, 24, "R3");
    xfer(8'h72, 16'h0008, 24, "R7");
    xfer(8'h03, 16'hBEEF, 24, "R3");
    // R4: write and update, B side then A side
    xfer(8'h43, 16'h5555, 24, "R4");
    xfer(8'h45, 16'hA5A5, 24, "R4");
    xfer(8'h4F, 16'hFFFF, 24, "R4");
    // R6: per-channel words
    xfer(8'h17, 16'h0C3F, 24, "R6");
    xfer(8'h2F, 16'h3FFC, 24, "R6");
    xfer(8'h30, 16'h8001, 24, "R6");
    // R7: bitmaps and config
    xfer(8'h71, 16'hF00F, 24, "R7");
    xfer(8'h73, 16'h0101, 24, "R7");
    xfer(8'h74, 16'h8421, 24, "R7");
    xfer(8'h70, 16'h0002, 24, "R7");
    // R9/R10/R11: chained reads
    therm = 16'h1C2D;
    xfer(8'h83, 16'h0000, 24, "R10");
    xfer(8'h85, 16'h0000, 24, "R10");
    xfer(8'h97, 16'h0000, 24, "R10");
    xfer(8'hAF, 16'h0000, 24, "R10");
    xfer(8'hB0, 16'h0000, 24, "R10");
    xfer(8'hF2, 16'h0000, 24, "R10");
    xfer(8'hF0, 16'h0000, 24, "R10");
    xfer(8'hF7, 16'h0000, 24, "R11");
    therm = 16'h0000;
    xfer(8'hC3, 16'h0000, 24, "R11");
    xfer(8'hF5, 16'h0000, 24, "R11");
    xfer(8'h83, 16'h0000, 24, "R11");
    xfer(8'h10, 16'h0000, 24, "R11");
    xfer(8'hFF, 16'h0000, 24, "R11");
    // R2: truncated and overlong frames
    xfer(8'h83, 16'h0000, 24, "R2");
    xfer(8'h01, 16'hFFFF, 12, "R2");
    xfer(8'h01, 16'hFFFF, 25, "R2");
    xfer(8'h72, 16'h0000, 23, "R2");
    xfer(8'hFF, 16'h0000, 24, "R2");
    // R12: ignored writes
    xfer(8'h77, 16'hFFFF, 24, "R12");
    xfer(8'h7E, 16'hFFFF, 24, "R12");
    xfer(8'h55, 16'hFFFF, 24, "R12");
    xfer(8'h75, 16'hFFFF, 24, "R12");
    xfer(8'h7B, 16'hFFFF, 24, "R12");
    // R5: update all with mixed select
    xfer(8'h00, 16'h0101, 24, "R3");
    xfer(8'h03, 16'h0303, 24, "R3");
    xfer(8'h72, 16'h0009, 24, "R7");
    xfer(8'h00, 16'h0B0B, 24, "R3");
    xfer(8'h7C, 16'h0000, 24, "R5");
    xfer(8'h80, 16'h0000, 24, "R10");
    xfer(8'hFF, 16'h0000, 24, "R10");
    // R8: soft reset via config top bit
    xfer(8'h70, 16'h8002, 24, "R8");
    xfer(8'h83, 16'h0000, 24, "R8");
    xfer(8'hFF, 16'h0000, 24, "R8");
    xfer(8'h4A, 16'h1357, 24, "R4");

    repeat (10) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule